// File: doc/BRIEF.md
# Inclusion-Aware Line Decay Controller

This block keeps one small saturating age counter for every line of an inclusive second-level cache and decides when a line has gone unused long enough to be switched off. A coarse global tick advances the counters. Hits and fills on the second-level cache reset a line's counter. Fills and evictions in the first-level cache change whether the line has a copy above it. A line is never gated while the first-level cache still holds a copy, so the inclusion property survives leakage saving.

There are two policies, chosen by `hybrid_mode`. In the age-always policy (`hybrid_mode`=0), a line keeps ageing while it has a first-level copy. If it expires in that state, the block raises a back-invalidate request, and it gates the line only after the first-level copy has been evicted. In the deferred policy (`hybrid_mode`=1), a line with a first-level copy is held in a low-voltage state with its age frozen. Ageing starts from zero when the first-level cache evicts it.

Event inputs are single-cycle strobes, each with a line index. They carry no ready signal and are always accepted, so there is no back-pressure. All outputs are plain per-line level signals.

Top module: `dcy_ctrl`

## Requirements
- R1: After reset every counter is zero, no line has a first-level copy, and `gate_off`, `drowsy` and `binv_req` are all zero.
- R2: Each `decay_tick` cycle advances by one the counter of every line that is counting. The counter saturates at 2^CNT_W-1 and never wraps.
- R3: A powered line whose counter is at its maximum and which has no first-level copy sets its `gate_off` bit at the next clock edge. The bit stays set until an L2 fill on that line.
- R4: An L2 fill on a line clears its counter, its `gate_off` bit and its first-level residency, and does so at the next edge.
- R5: An L2 hit on a line clears its counter.
- R6: With `hybrid_mode`=0, a line with a first-level copy keeps counting on ticks, and an L1 fill does not clear its counter.
- R7: With `hybrid_mode`=0, an L1 eviction clears only the line's residency and leaves its counter unchanged.
- R8: A line that is at its maximum count and has a first-level copy holds its `binv_req` bit and stays powered. After the L1 eviction of that line, `binv_req` drops at that edge and `gate_off` rises one edge later.
- R9: With `hybrid_mode`=1, an L1 fill clears the line's counter, and the counter does not advance while the copy is resident.
- R10: With `hybrid_mode`=1, an L1 eviction clears the line's counter, and counting then resumes on later ticks.
- R11: With `hybrid_mode`=1, a powered line with a first-level copy shows a one in its `drowsy` bit. The bit is zero in all other cases.
- R12: If a line event and a tick arrive in the same cycle, the event's counter clear wins. No line is gated in a cycle in which it receives any event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hybrid_mode | input | 1 | 0: age-always policy, 1: deferred policy |
| decay_tick | input | 1 | Global coarse decay tick |
| l2_hit_vld | input | 1 | L2 hit strobe |
| l2_hit_idx | input | IDX_W | Line index of the L2 hit |
| l2_fill_vld | input | 1 | L2 fill strobe |
| l2_fill_idx | input | IDX_W | Line index of the L2 fill |
| l1_fill_vld | input | 1 | L1 fill strobe (line gains a first-level copy) |
| l1_fill_idx | input | IDX_W | Line index of the L1 fill |
| l1_evict_vld | input | 1 | L1 eviction strobe (first-level copy leaves) |
| l1_evict_idx | input | IDX_W | Line index of the L1 eviction |
| gate_off | output | N_LINES | Per-line supply gate-off and invalidate request |
| drowsy | output | N_LINES | Per-line low-voltage request |
| binv_req | output | N_LINES | Per-line back-invalidate request to the L1 |

## Verification
The bench builds the block with four lines and 2-bit counters. With these values every per-line output fits in one 4-bit vector that is compared whole, and expiry is reached after three ticks. This makes it practical to sweep fills across every line index and to check each step towards saturation and past it. Both policies are run with two lines resident in the first-level cache and two not, so residency-driven and age-driven outcomes are seen side by side in the same vector.

// File: rtl/dcy_pkg.sv
package dcy_pkg;
  typedef enum int unsigned {
    EV_HIT    = 0,
    EV_FILL   = 1,
    EV_L1FILL = 2,
    EV_L1EVCT = 3,
    EV_NUM    = 4
  } ev_kind_e;
endpackage

// File: rtl/dcy_evt_dec.sv
module dcy_evt_dec #(
  parameter int N_LINES = 16,
  parameter int IDX_W   = 4
) (
  input  logic               vld,
  input  logic [IDX_W-1:0]   idx,
  output logic [N_LINES-1:0] hot
);
  for (genvar i = 0; i < N_LINES; i++) begin : g_hot
    assign hot[i] = vld && (idx == IDX_W'(i));
  end
endmodule

// File: rtl/dcy_line.sv
module dcy_line #(
  parameter int CNT_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hybrid_mode,
  input  logic tick,
  input  logic hit,
  input  logic fill,
  input  logic l1_fill,
  input  logic l1_evict,
  output logic gate_off,
  output logic drowsy,
  output logic binv
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic incl_q, incl_d;
  logic off_q, off_d;
  logic clr_cnt, any_evt, cnt_en, at_max;

  assign any_evt = hit | fill | l1_fill | l1_evict;
  assign clr_cnt = hit | fill | (hybrid_mode & (l1_fill | l1_evict));
  assign cnt_en  = !off_q && (hybrid_mode ? !incl_q : 1'b1);
  assign at_max  = (cnt_q == CNT_MAX);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_cnt)
      cnt_d = '0;
    else if (tick && cnt_en && !at_max)
      cnt_d = cnt_q + 1'b1;
  end

  always_comb begin
    incl_d = incl_q;
    if (l1_fill)
      incl_d = 1'b1;
    else if (l1_evict || fill)
      incl_d = 1'b0;
  end

  always_comb begin
    if (fill)
      off_d = 1'b0;
    else if (off_q)
      off_d = 1'b1;
    else
      off_d = at_max && !incl_q && !any_evt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      incl_q <= 1'b0;
      off_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      incl_q <= incl_d;
      off_q  <= off_d;
    end
  end

  assign gate_off = off_q;
  assign drowsy   = hybrid_mode && incl_q && !off_q;
  assign binv     = at_max && incl_q && !off_q;

  AST_FILL_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    fill |=> (!gate_off && cnt_q == '0)); // R4
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (at_max && !hit && !fill && !(hybrid_mode && (l1_fill || l1_evict))) |=> at_max); // R2
  AST_GATE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_off) |-> !incl_q); // R8
  AST_HYB_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (hybrid_mode && incl_q && !hit && !fill && !l1_fill && !l1_evict) |=> $stable(cnt_q)); // R9
  AST_MOD_EVICT: assert property (@(posedge clk) disable iff (!rst_n)
    (!hybrid_mode && l1_evict && !hit && !fill && !l1_fill && !tick) |=> $stable(cnt_q)); // R7
  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (hit || fill)) |=> (cnt_q == '0)); // R12
  AST_NO_GATE_ON_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_off && any_evt) |=> !gate_off); // R12
endmodule

// File: rtl/dcy_ctrl.sv
module dcy_ctrl #(
  parameter int N_LINES = 16,
  parameter int CNT_W   = 2,
  localparam int IDX_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hybrid_mode,
  input  logic               decay_tick,
  input  logic               l2_hit_vld,
  input  logic [IDX_W-1:0]   l2_hit_idx,
  input  logic               l2_fill_vld,
  input  logic [IDX_W-1:0]   l2_fill_idx,
  input  logic               l1_fill_vld,
  input  logic [IDX_W-1:0]   l1_fill_idx,
  input  logic               l1_evict_vld,
  input  logic [IDX_W-1:0]   l1_evict_idx,
  output logic [N_LINES-1:0] gate_off,
  output logic [N_LINES-1:0] drowsy,
  output logic [N_LINES-1:0] binv_req
);
  import dcy_pkg::*;

  logic [EV_NUM-1:0]  ev_vld;
  logic [IDX_W-1:0]   ev_idx [EV_NUM];
  logic [N_LINES-1:0] ev_hot [EV_NUM];

  assign ev_vld[EV_HIT]    = l2_hit_vld;
  assign ev_vld[EV_FILL]   = l2_fill_vld;
  assign ev_vld[EV_L1FILL] = l1_fill_vld;
  assign ev_vld[EV_L1EVCT] = l1_evict_vld;
  assign ev_idx[EV_HIT]    = l2_hit_idx;
  assign ev_idx[EV_FILL]   = l2_fill_idx;
  assign ev_idx[EV_L1FILL] = l1_fill_idx;
  assign ev_idx[EV_L1EVCT] = l1_evict_idx;

  for (genvar e = 0; e < EV_NUM; e++) begin : g_dec
    dcy_evt_dec #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_dec (
      .vld (ev_vld[e]),
      .idx (ev_idx[e]),
      .hot (ev_hot[e])
    );
  end

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    dcy_line #(.CNT_W(CNT_W)) u_line (
      .clk         (clk),
      .rst_n       (rst_n),
      .hybrid_mode (hybrid_mode),
      .tick        (decay_tick),
      .hit         (ev_hot[EV_HIT][i]),
      .fill        (ev_hot[EV_FILL][i]),
      .l1_fill     (ev_hot[EV_L1FILL][i]),
      .l1_evict    (ev_hot[EV_L1EVCT][i]),
      .gate_off    (gate_off[i]),
      .drowsy      (drowsy[i]),
      .binv        (binv_req[i])
    );
  end

  AST_DROWSY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (!hybrid_mode) |-> (drowsy == '0)); // R11
  AST_BINV_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (binv_req & gate_off) == '0); // R8
endmodule

// File: tb/dcy_ctrl_bench.sv
module dcy_ctrl_bench;
  localparam int N = 4;
  localparam int CW = 2;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hybrid_mode = 1'b0;
  logic decay_tick = 1'b0;
  logic l2_hit_vld = 1'b0, l2_fill_vld = 1'b0, l1_fill_vld = 1'b0, l1_evict_vld = 1'b0;
  logic [IW-1:0] ev_idx = '0;
  logic [N-1:0] gate_off, drowsy, binv_req;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dcy_ctrl #(.N_LINES(N), .CNT_W(CW)) u_dcy_ctrl (
    .clk(clk), .rst_n(rst_n), .hybrid_mode(hybrid_mode), .decay_tick(decay_tick),
    .l2_hit_vld(l2_hit_vld), .l2_hit_idx(ev_idx),
    .l2_fill_vld(l2_fill_vld), .l2_fill_idx(ev_idx),
    .l1_fill_vld(l1_fill_vld), .l1_fill_idx(ev_idx),
    .l1_evict_vld(l1_evict_vld), .l1_evict_idx(ev_idx),
    .gate_off(gate_off), .drowsy(drowsy), .binv_req(binv_req)
  );

  // kind bits: 0 tick, 1 hit, 2 L2 fill, 3 L1 fill, 4 L1 evict
  task automatic evt(input logic [4:0] kind, input int idx);
    @(negedge clk);
    decay_tick   = kind[0];
    l2_hit_vld   = kind[1];
    l2_fill_vld  = kind[2];
    l1_fill_vld  = kind[3];
    l1_evict_vld = kind[4];
    ev_idx       = IW'(idx);
    @(negedge clk);
    {decay_tick, l2_hit_vld, l2_fill_vld, l1_fill_vld, l1_evict_vld} = '0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) evt(5'b00001, 0);
  endtask

  task automatic fill_all();
    for (int i = 0; i < N; i++) evt(5'b00100, i);
  endtask

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 gate", gate_off, '0);
    chk("R1 drowsy", drowsy, '0);
    chk("R1 binv", binv_req, '0);

    // R2/R3: all lines age from reset in age-always policy
    ticks(2); @(negedge clk);
    chk("R2 two ticks", gate_off, '0);
    ticks(1);
    chk("R3 max reached, not yet gated", gate_off, '0);
    @(negedge clk);
    chk("R3 gated one edge later", gate_off, 4'hF);
    ticks(2); @(negedge clk);
    chk("R2 saturated stays off", gate_off, 4'hF);

    // R4: fill sweep across every index
    for (int i = 0; i < N; i++) begin
      evt(5'b00100, i);
      chk("R4 fill wakes line", gate_off, 4'hF & ~((4'h1 << (i + 1)) - 4'h1));
    end

    // R5: hit on line 2 restarts its age
    ticks(2); evt(5'b00010, 2); ticks(1); @(negedge clk);
    chk("R5 hit reset", gate_off, 4'b1011);
    ticks(2); @(negedge clk);
    chk("R5 line 2 expires later", gate_off, 4'hF);

    // R6/R7/R8: residency in age-always policy
    fill_all();
    evt(5'b01000, 0); evt(5'b01000, 1);
    ticks(2); evt(5'b10000, 1); ticks(1); @(negedge clk);
    chk("R6 R7 resident line ages, evict keeps age", gate_off, 4'b1110);
    chk("R8 back-invalidate raised", binv_req, 4'b0001);
    chk("R11 no drowsy in age-always", drowsy, '0);
    evt(5'b10000, 0);
    chk("R8 binv drops on evict", binv_req, '0);
    chk("R12 no gate in event cycle", gate_off, 4'b1110);
    @(negedge clk);
    chk("R8 gated after evict", gate_off, 4'hF);

    // R9/R10/R11: deferred policy
    hybrid_mode = 1'b1;
    fill_all();
    evt(5'b01000, 0); evt(5'b01000, 1);
    chk("R11 drowsy for resident lines", drowsy, 4'b0011);
    ticks(5); @(negedge clk);
    chk("R9 resident lines frozen", gate_off, 4'b1100);
    chk("R9 no binv", binv_req, '0);
    evt(5'b10000, 1);
    chk("R11 drowsy clears on evict", drowsy, 4'b0001);
    ticks(2); @(negedge clk);
    chk("R10 counting from zero", gate_off, 4'b1100);
    ticks(1); @(negedge clk);
    chk("R10 expires after evict", gate_off, 4'b1110);

    // R12: tick and hit in the same cycle
    hybrid_mode = 1'b0;
    fill_all();
    ticks(2); evt(5'b00011, 3); ticks(1); @(negedge clk);
    chk("R12 event wins over tick", gate_off, 4'b0111);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule